// File: doc/BRIEF.md
# Per-Trigger Dead-Time Recorder

After each accepted trigger the block times five level signals in parallel: the trigger strobe itself, the total dead-time line, the ADC busy line, the QDC busy line and the combined veto. The measurement window opens on the trigger cycle and closes on the first later cycle in which the combined veto is low. Each duration is a count of clock cycles in which that signal was high inside the window. A counter stops at its maximum value and does not wrap.

When the window closes, the five durations and a per-trigger sequence number go into a word FIFO as one three-word record, written in three consecutive cycles. If fewer than three words are free, the whole record is discarded and a sticky overflow flag is raised. A host pops one 32-bit word per read strobe and watches a status word that reports occupancy and four flags.

Top module: `deadtime_recorder`

## Requirements
- R1: For each accepted trigger, every duration counter equals the number of clock cycles its signal was high, counted from the trigger cycle through the last cycle before the combined veto is first seen low. The trigger duration covers all cycles in which the trigger input was high in that window.
- R2: A duration counter holds at 0xFFFF once it reaches that value and does not wrap.
- R3: A record is three FIFO words, in this order. Word 0 has the veto duration in bits 31:16 and the trigger duration in 15:0. Word 1 has the ADC busy duration in 31:16 and the QDC busy duration in 15:0. Word 2 has the dead-time duration in 31:16 and the sequence number in 15:0.
- R4: The record is written only after the window closes. Occupancy rises by exactly three within four cycles of the veto being seen low.
- R5: The sequence number is 0 for the first trigger after reset. It advances by one for every completed measurement, whether that record was stored or discarded.
- R6: If fewer than three words are free when the window closes, nothing is written, occupancy is unchanged and the overflow flag is set. The flag stays set until it is cleared.
- R7: A one-cycle pulse on the overflow clear input clears the overflow flag. If a discard happens in the same cycle, setting the flag takes priority.
- R8: The status word carries occupancy in bits 12:0, empty in bit 16, full in bit 17, almost-full in bit 18 and overflow in bit 19. Almost-full means fewer than three words are free. All other bits read 0.
- R9: A read strobe on a non-empty FIFO pops the oldest word, which appears on the data output after the next clock edge. A read strobe on an empty FIFO returns 0 and leaves the occupancy unchanged.
- R10: A trigger that arrives while a measurement or a record write is in progress does not start a new measurement and consumes no sequence number.
- R11: After reset the FIFO is empty, the overflow flag is clear, the status word reads 0x00010000 and the data output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | One-cycle accepted-trigger strobe |
| deadtime_i | input | 1 | Total dead-time level |
| adc_busy_i | input | 1 | ADC busy level |
| qdc_busy_i | input | 1 | QDC busy level |
| veto_i | input | 1 | Combined veto level (OR of the four contributors) |
| rd_i | input | 1 | Host read strobe, pops one word |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| rd_data_o | output | 32 | Word popped by the last read |
| status_o | output | 32 | Occupancy and flags |

## Verification
The assertions assume that the combined veto really is the OR of the trigger and the three busy lines, so that no contributor count can ever exceed the veto count at the close of a window. They also assume that the trigger strobe comes with the veto high in the same cycle. The bench meets both assumptions: for each stimulus it drives the veto high for at least as long as the longest contributor, starting on the trigger cycle, and drops every contributor no later than the veto. The one trigger it sends during a record write is likewise paired with the veto.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_WR   = 2'd2
  } dtr_state_e;

  localparam int unsigned NSIG      = 5;
  localparam int unsigned SIG_TRIG  = 0;
  localparam int unsigned SIG_DEAD  = 1;
  localparam int unsigned SIG_ADC   = 2;
  localparam int unsigned SIG_QDC   = 3;
  localparam int unsigned SIG_VETO  = 4;

  localparam int unsigned REC_WORDS = 3;
  localparam int unsigned IDX_W     = 2;

  localparam int unsigned STAT_EMPTY = 16;
  localparam int unsigned STAT_FULL  = 17;
  localparam int unsigned STAT_AFULL = 18;
  localparam int unsigned STAT_OVF   = 19;

endpackage

// File: rtl/dtr_reset_sync.sv
module dtr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dtr_span_counter.sv
module dtr_span_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             level_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start_i) begin
      cnt_en = 1'b1;
      cnt_d  = {{(CNT_W-1){1'b0}}, level_i};
    end else if (run_i && level_i && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/dtr_record_ctrl.sv
module dtr_record_ctrl
  import deadtime_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             veto_i,
  input  logic             room_ok_i,
  input  logic             ovf_clr_i,
  output logic             start_o,
  output logic             run_o,
  output logic             meas_end_o,
  output logic             drop_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] seq_o,
  output logic             ovf_o
);
  dtr_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] seq_q, seq_d;
  logic             ovf_q, ovf_d;
  logic             last_wr;

  always_comb begin
    start_o    = (state_q == ST_IDLE) && trig_i;
    run_o      = (state_q == ST_MEAS);
    meas_end_o = run_o && !veto_i;
    drop_o     = meas_end_o && !room_ok_i;
    wr_en_o    = (state_q == ST_WR);
    last_wr    = wr_en_o && (idx_q == IDX_W'(REC_WORDS - 1));

    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_o)    state_d = ST_MEAS;
      ST_MEAS: if (meas_end_o) state_d = room_ok_i ? ST_WR : ST_IDLE;
      ST_WR:   if (last_wr)    state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase

    idx_d = idx_q;
    if (meas_end_o)   idx_d = '0;
    else if (wr_en_o) idx_d = idx_q + 1'b1;

    seq_d = seq_q;
    if (drop_o || last_wr) seq_d = seq_q + 1'b1;

    ovf_d = ovf_q;
    if (drop_o)         ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      seq_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      seq_q   <= seq_d;
      ovf_q   <= ovf_d;
    end
  end

  assign wr_idx_o = idx_q;
  assign seq_o    = seq_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/dtr_word_fifo.sv
module dtr_word_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [OCC_W-1:0] occ_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [DW-1:0]    rdat_q, rdat_d;
  logic             do_rd;

  always_comb begin
    do_rd  = rd_i && (occ_q != '0);
    wptr_d = wr_en_i ? wptr_q + 1'b1 : wptr_q;
    rptr_d = do_rd   ? rptr_q + 1'b1 : rptr_q;
    occ_d  = occ_q;
    if (wr_en_i && !do_rd)      occ_d = occ_q + 1'b1;
    else if (!wr_en_i && do_rd) occ_d = occ_q - 1'b1;
    rdat_d = rdat_q;
    if (rd_i) rdat_d = do_rd ? mem[rptr_q] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
      rdat_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      occ_q  <= occ_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_data_o = rdat_q;
  assign occ_o     = occ_q;
endmodule

// File: rtl/deadtime_recorder.sv
module deadtime_recorder
  import deadtime_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              deadtime_i,
  input  logic              adc_busy_i,
  input  logic              qdc_busy_i,
  input  logic              veto_i,
  input  logic              rd_i,
  input  logic              ovf_clr_i,
  output logic [2*CNT_W-1:0] rd_data_o,
  output logic [31:0]       status_o
);
  localparam int unsigned DW    = 2 * CNT_W;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic             rst_sync_n;
  logic             start, run, meas_end, drop, wr_en, ovf, room_ok, full;
  logic [IDX_W-1:0] wr_idx;
  logic [CNT_W-1:0] seq;
  logic [NSIG-1:0]  lvl;
  logic [CNT_W-1:0] span_cnt [NSIG];
  logic [CNT_W-1:0] trig_cnt, dead_cnt, adc_cnt, qdc_cnt, veto_cnt;
  logic [DW-1:0]    wr_word;
  logic [OCC_W-1:0] occ, free_words;

  dtr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    lvl           = '0;
    lvl[SIG_TRIG] = trig_i;
    lvl[SIG_DEAD] = deadtime_i;
    lvl[SIG_ADC]  = adc_busy_i;
    lvl[SIG_QDC]  = qdc_busy_i;
    lvl[SIG_VETO] = veto_i;
  end

  for (genvar g = 0; g < NSIG; g++) begin : g_span
    dtr_span_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .start_i (start),
      .run_i   (run),
      .level_i (lvl[g]),
      .count_o (span_cnt[g])
    );
  end

  assign trig_cnt = span_cnt[SIG_TRIG];
  assign dead_cnt = span_cnt[SIG_DEAD];
  assign adc_cnt  = span_cnt[SIG_ADC];
  assign qdc_cnt  = span_cnt[SIG_QDC];
  assign veto_cnt = span_cnt[SIG_VETO];

  assign free_words = OCC_W'(DEPTH) - occ;
  assign room_ok    = free_words >= OCC_W'(REC_WORDS);
  assign full       = (occ == OCC_W'(DEPTH));

  dtr_record_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig_i     (trig_i),
    .veto_i     (veto_i),
    .room_ok_i  (room_ok),
    .ovf_clr_i  (ovf_clr_i),
    .start_o    (start),
    .run_o      (run),
    .meas_end_o (meas_end),
    .drop_o     (drop),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .seq_o      (seq),
    .ovf_o      (ovf)
  );

  always_comb begin
    case (wr_idx)
      IDX_W'(0): wr_word = {veto_cnt, trig_cnt};
      IDX_W'(1): wr_word = {adc_cnt, qdc_cnt};
      default:   wr_word = {dead_cnt, seq};
    endcase
  end

  dtr_word_fifo #(.DW(DW), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_word),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .occ_o     (occ)
  );

  always_comb begin
    status_o             = '0;
    status_o[OCC_W-1:0]  = occ;
    status_o[STAT_EMPTY] = (occ == '0);
    status_o[STAT_FULL]  = full;
    status_o[STAT_AFULL] = !room_ok;
    status_o[STAT_OVF]   = ovf;
  end
endmodule

// File: rtl/deadtime_recorder_chk.sv
module deadtime_recorder_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned OCC_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_i,
  input logic             ovf_clr_i,
  input logic [2*CNT_W-1:0] rd_data_o,
  input logic             start,
  input logic             meas_end,
  input logic             drop,
  input logic             wr_en,
  input logic             ovf,
  input logic [OCC_W-1:0] occ,
  input logic [CNT_W-1:0] trig_cnt,
  input logic [CNT_W-1:0] dead_cnt,
  input logic [CNT_W-1:0] adc_cnt,
  input logic [CNT_W-1:0] qdc_cnt,
  input logic [CNT_W-1:0] veto_cnt
);
  // R1: the combined veto outlasts every contributor
  p_veto_longest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    meas_end |-> (veto_cnt >= dead_cnt) && (veto_cnt >= adc_cnt) &&
                 (veto_cnt >= qdc_cnt) && (veto_cnt >= trig_cnt));

  // R2: a saturated counter stays saturated until the next start
  p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && veto_cnt == {CNT_W{1'b1}}) |=> (veto_cnt == {CNT_W{1'b1}}));

  // R3: record words are written back to back
  p_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |=> wr_en);

  // R6: a discarded record writes nothing in the next cycle
  p_drop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !wr_en);

  // R6: overflow is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr_i) |=> ovf);

  // R7: the clear strobe clears overflow when no discard competes
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_i && !drop) |=> !ovf);

  // R8: occupancy never exceeds the depth
  p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  // R9: reading an empty FIFO returns zero and keeps it empty
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && occ == '0 && !wr_en) |=> (rd_data_o == '0) && (occ == '0));
endmodule

bind deadtime_recorder deadtime_recorder_chk #(
  .CNT_W(CNT_W), .DEPTH(DEPTH), .OCC_W(OCC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_i      (rd_i),
  .ovf_clr_i (ovf_clr_i),
  .rd_data_o (rd_data_o),
  .start     (start),
  .meas_end  (meas_end),
  .drop      (drop),
  .wr_en     (wr_en),
  .ovf       (ovf),
  .occ       (occ),
  .trig_cnt  (trig_cnt),
  .dead_cnt  (dead_cnt),
  .adc_cnt   (adc_cnt),
  .qdc_cnt   (qdc_cnt),
  .veto_cnt  (veto_cnt)
);

// File: tb/deadtime_recorder_tb.sv
module deadtime_recorder_tb;
  logic        clk;
  logic        rst_n;
  logic        trig_i, deadtime_i, adc_busy_i, qdc_busy_i, veto_i, rd_i, ovf_clr_i;
  logic [31:0] rd_data_o, status_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  deadtime_recorder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .deadtime_i (deadtime_i),
    .adc_busy_i (adc_busy_i),
    .qdc_busy_i (qdc_busy_i),
    .veto_i     (veto_i),
    .rd_i       (rd_i),
    .ovf_clr_i  (ovf_clr_i),
    .rd_data_o  (rd_data_o),
    .status_o   (status_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // One trigger; each line high for its length from the trigger cycle.
  task automatic pulse(input int v, input int t, input int a, input int q);
    for (int i = 0; i < v; i++) begin
      @(negedge clk);
      trig_i     = (i == 0);
      veto_i     = 1'b1;
      deadtime_i = (i < t);
      adc_busy_i = (i < a);
      qdc_busy_i = (i < q);
    end
    @(negedge clk);
    trig_i = 0; veto_i = 0; deadtime_i = 0; adc_busy_i = 0; qdc_busy_i = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic read_record(input string req, input int v, input int t,
                             input int a, input int q, input int seq);
    logic [31:0] d;
    pop(d); check({req, " word0 veto/trigger (R3)"}, d, {v[15:0], 16'd1});
    pop(d); check({req, " word1 adc/qdc (R3)"}, d, {a[15:0], q[15:0]});
    pop(d); check({req, " word2 deadtime/seq (R3 R5)"}, d, {t[15:0], seq[15:0]});
  endtask

  task automatic t_reset();
    check("R11 status after reset", status_o, 32'h0001_0000);
    check("R11 data after reset", rd_data_o, 32'h0);
  endtask

  task automatic t_basic();
    pulse(5, 3, 2, 4);
    check("R4 occupancy after one record", status_o, 32'h0000_0003);
    read_record("R1 basic", 5, 3, 2, 4, 0);
    check("R9 occupancy after three pops", status_o, 32'h0001_0000);
  endtask

  task automatic t_pattern();
    pulse(9, 4, 9, 0);
    read_record("R1 adc equals veto", 9, 4, 9, 0, 1);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    pop(d);
    check("R9 empty read data", d, 32'h0);
    check("R9 empty read occupancy", status_o, 32'h0001_0000);
  endtask

  task automatic t_trig_during_write();
    @(negedge clk);
    trig_i = 1; veto_i = 1; deadtime_i = 1;
    @(negedge clk);
    trig_i = 0; veto_i = 1; deadtime_i = 0;
    @(negedge clk);
    veto_i = 0;            // window closes at the next edge
    @(negedge clk);
    trig_i = 1; veto_i = 1; // arrives while the record is written
    @(negedge clk);
    trig_i = 0; veto_i = 0;
    repeat (10) @(negedge clk);
    check("R10 only one record stored", status_o, 32'h0000_0003);
    read_record("R10 record", 2, 1, 0, 0, 2);
  endtask

  task automatic t_saturate();
    pulse(70000, 70000, 3, 0);
    read_record("R2 saturated", 65535, 65535, 3, 0, 3);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    for (int i = 0; i < 1365; i++) pulse(2, 1, 0, 0);
    check("R8 almost full at 4095", status_o, 32'h0004_0FFF);
    pulse(2, 1, 0, 0);
    check("R6 record dropped, overflow set", status_o, 32'h000C_0FFF);
    pop(d); pop(d);
    check("R8 almost-full clears with room", status_o, 32'h0008_0FFD);
    pulse(2, 1, 0, 0);
    check("R8 full at 4096, overflow sticky (R6)", status_o, 32'h000E_1000);
    @(negedge clk); ovf_clr_i = 1;
    @(negedge clk); ovf_clr_i = 0;
    check("R7 overflow cleared", status_o, 32'h0006_1000);
    for (int i = 0; i < 4093; i++) pop(d);
    read_record("R5 seq after drop", 2, 1, 0, 0, 1370);
    check("R9 drained", status_o, 32'h0001_0000);
  endtask

  initial begin
    rst_n = 0; trig_i = 0; deadtime_i = 0; adc_busy_i = 0; qdc_busy_i = 0;
    veto_i = 0; rd_i = 0; ovf_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_pattern();
    t_empty_read();
    t_trig_during_write();
    t_saturate();
    t_fill();
    finish_run();
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule